// File: doc/BRIEF.md
# Packed Register Init Table Loader

This block walks a packed set-up table held in a read-only memory once, straight after reset, and turns it into write transactions on a simple register/memory write bus. The table is a run of records. Each record opens with a control byte that selects a target space and a byte count. Depending on the space, one or two address bytes follow, then the payload bytes. The block stops at a terminator and raises a done flag, which the rest of the system waits for before it starts normal operation.

There are four target spaces. Internal RAM takes a one-byte address. External space takes either a full two-byte address or a one-byte offset into a fixed page. The fourth space sets or clears single bits of internal RAM by reading the containing byte, changing one bit and writing the byte back. The ROM has one cycle of read latency, and so does the internal RAM read path used by the bit space. In the byte spaces the block issues one write per clock once a record's payload starts.

Top module: `init_table_loader`

## Requirements
- R1: Control byte bits [7:6] select the space. 00 is internal RAM, with one address byte (write address = {8'h00, byte}, wr_ext_o=0). 01 is external, with two address bytes, high byte first (wr_ext_o=1). 10 is bit set/clear in internal RAM, with no address bytes. 11 is external, with one address byte (write address = {XPAGE, byte}, wr_ext_o=1).
- R2: When control bit 5 is clear, bits [4:0] give the record's payload byte count.
- R3: When control bit 5 is set, the byte after the control byte extends the count, and the count becomes {ctrl[4:0], next_byte}. The address bytes follow this extension byte.
- R4: Payload bytes are written in table order, one write per byte, starting at the record address and going up by one for each byte. The upper address bits carry when the low byte wraps.
- R5: In the bit space, each payload byte b names internal byte BIT_BASE + b[6:3] and bit b[2:0], and b[7] is the new value. The block reads that byte and then, two cycles after the read strobe, writes it back with only the named bit replaced. Bits written in turn to the same byte accumulate.
- R6: A control byte of 0x00, or a record whose count is zero in either count form, ends the table. done_o then rises and stays high. After that no further write or read is issued and the ROM address stays constant.
- R7: After reset release the block starts at ROM address 0 on its own and reads the table strictly in order. During reset done_o, wr_en_o and rd_en_o are low and rom_addr_o is 0.
- R8: Within a byte-space record, payload writes come on consecutive clock cycles with no gap.
- R9: A read and a write are never issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rom_addr_o | output | ROM_AW | Table ROM address |
| rom_data_i | input | 8 | Table ROM data, one cycle after its address |
| wr_en_o | output | 1 | Write strobe |
| wr_ext_o | output | 1 | 1 = external space, 0 = internal RAM |
| wr_addr_o | output | 16 | Write address |
| wr_data_o | output | 8 | Write data |
| rd_en_o | output | 1 | Internal RAM read strobe (bit space) |
| rd_addr_o | output | 8 | Internal RAM read address |
| rd_data_i | input | 8 | Internal RAM read data, one cycle after rd_en_o |
| done_o | output | 1 | Table finished |

## Verification
The bench aims at the count forms. A long count whose extension byte pushes a record past 255 bytes catches a loader that only decodes five bits and cuts the record short. Zero counts in the long form and in a non-zero space catch a loader that only treats 0x00 as the end and so runs into the trailing garbage. Several bit writes to one byte catch a read-modify-write that overwrites neighbouring bits or reads stale data. The one-byte external space and a low-byte address wrap catch a wrong page or a missing carry. A one-byte-short payload walk would leave every later record misparsed, and random tables compared write by write against a model of the table show this at once.

// File: rtl/initld_pkg.sv
package initld_pkg;
  localparam int DW    = 8;
  localparam int XAW   = 16;
  localparam int CNT_W = 13;

  typedef enum logic [1:0] {
    SP_IRAM   = 2'b00,
    SP_XLONG  = 2'b01,
    SP_BIT    = 2'b10,
    SP_XSHORT = 2'b11
  } space_e;

  typedef enum logic [3:0] {
    ST_CTRL, ST_CNT2, ST_AHI, ST_ALO, ST_DATA,
    ST_BRD, ST_BWAIT, ST_BWR, ST_DONE
  } state_e;
endpackage

// File: rtl/initld_fetch.sv
module initld_fetch #(
  parameter int ROM_AW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic              vld_o
);
  logic [ROM_AW-1:0] ptr_q;
  logic              vld_q;

  // ptr_q is the address whose data sits on the ROM output now
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= 1'b1;
      if (take_i) ptr_q <= ptr_q + ROM_AW'(1);
    end
  end

  assign rom_addr_o = take_i ? ptr_q + ROM_AW'(1) : ptr_q;
  assign vld_o      = vld_q;

  assert_take_vld_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> vld_o);
  assert_in_order_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> (rom_addr_o == $past(rom_addr_o)) || (rom_addr_o == $past(rom_addr_o) + ROM_AW'(1)));
endmodule

// File: rtl/initld_bitop.sv
module initld_bitop #(
  parameter logic [7:0] BIT_BASE = 8'h20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] bit_byte_i,
  input  logic [7:0] rd_data_i,
  output logic [7:0] byte_addr_o,
  output logic [7:0] merged_o
);
  logic [2:0] idx_q;
  logic       val_q;

  assign byte_addr_o = BIT_BASE + {4'h0, bit_byte_i[6:3]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      val_q <= 1'b0;
    end else if (load_i) begin
      idx_q <= bit_byte_i[2:0];
      val_q <= bit_byte_i[7];
    end
  end

  for (genvar g = 0; g < 8; g++) begin : g_merge
    assign merged_o[g] = (idx_q == 3'(g)) ? val_q : rd_data_i[g];
  end
endmodule

// File: rtl/initld_seq.sv
module initld_seq
  import initld_pkg::*;
#(
  parameter logic [7:0] XPAGE = 8'hE6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           vld_i,
  input  logic [DW-1:0]  byte_i,
  input  logic [7:0]     byte_addr_i,
  input  logic [7:0]     merged_i,
  output logic           take_o,
  output logic           bit_load_o,
  output logic           wr_en_o,
  output logic           wr_ext_o,
  output logic [XAW-1:0] wr_addr_o,
  output logic [DW-1:0]  wr_data_o,
  output logic           rd_en_o,
  output logic [7:0]     rd_addr_o,
  output logic           done_o
);
  state_e           st_q, st_d;
  space_e           sp_q, sp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [XAW-1:0]   addr_q, addr_d;
  logic [4:0]       cnthi_q, cnthi_d;
  logic             wr_en_d, wr_ext_d, rd_en_d;
  logic [XAW-1:0]   wr_addr_d;
  logic [DW-1:0]    wr_data_d;
  logic [7:0]       rd_addr_d;

  function automatic state_e after_count(space_e sp);
    case (sp)
      SP_BIT:   return ST_BRD;
      SP_XLONG: return ST_AHI;
      default:  return ST_ALO;
    endcase
  endfunction

  always_comb begin
    st_d       = st_q;
    sp_d       = sp_q;
    cnt_d      = cnt_q;
    addr_d     = addr_q;
    cnthi_d    = cnthi_q;
    take_o     = 1'b0;
    bit_load_o = 1'b0;
    wr_en_d    = 1'b0;
    wr_ext_d   = wr_ext_o;
    wr_addr_d  = wr_addr_o;
    wr_data_d  = wr_data_o;
    rd_en_d    = 1'b0;
    rd_addr_d  = rd_addr_o;
    case (st_q)
      ST_CTRL: if (vld_i) begin
        take_o = 1'b1;
        sp_d   = space_e'(byte_i[7:6]);
        if (byte_i[5]) begin
          cnthi_d = byte_i[4:0];
          st_d    = ST_CNT2;
        end else if (byte_i[4:0] == 5'd0) begin
          st_d = ST_DONE;
        end else begin
          cnt_d = CNT_W'(byte_i[4:0]);
          st_d  = after_count(space_e'(byte_i[7:6]));
        end
      end
      ST_CNT2: if (vld_i) begin
        take_o = 1'b1;
        cnt_d  = {cnthi_q, byte_i};
        if ({cnthi_q, byte_i} == '0) st_d = ST_DONE;
        else                         st_d = after_count(sp_q);
      end
      ST_AHI: if (vld_i) begin
        take_o       = 1'b1;
        addr_d[15:8] = byte_i;
        st_d         = ST_ALO;
      end
      ST_ALO: if (vld_i) begin
        take_o      = 1'b1;
        addr_d[7:0] = byte_i;
        if (sp_q == SP_XSHORT)   addr_d[15:8] = XPAGE;
        else if (sp_q == SP_IRAM) addr_d[15:8] = 8'h00;
        st_d = ST_DATA;
      end
      ST_DATA: if (vld_i) begin
        take_o    = 1'b1;
        wr_en_d   = 1'b1;
        wr_ext_d  = (sp_q != SP_IRAM);
        wr_addr_d = addr_q;
        wr_data_d = byte_i;
        addr_d    = addr_q + XAW'(1);
        cnt_d     = cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) st_d = ST_CTRL;
      end
      ST_BRD: if (vld_i) begin
        take_o     = 1'b1;
        bit_load_o = 1'b1;
        rd_en_d    = 1'b1;
        rd_addr_d  = byte_addr_i;
        st_d       = ST_BWAIT;
      end
      ST_BWAIT: st_d = ST_BWR;
      ST_BWR: begin
        wr_en_d   = 1'b1;
        wr_ext_d  = 1'b0;
        wr_addr_d = {8'h00, rd_addr_o};
        wr_data_d = merged_i;
        cnt_d     = cnt_q - CNT_W'(1);
        st_d      = (cnt_q == CNT_W'(1)) ? ST_CTRL : ST_BRD;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_CTRL;
      sp_q      <= SP_IRAM;
      cnt_q     <= '0;
      addr_q    <= '0;
      cnthi_q   <= '0;
      wr_en_o   <= 1'b0;
      wr_ext_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      rd_en_o   <= 1'b0;
      rd_addr_o <= '0;
      done_o    <= 1'b0;
    end else begin
      st_q      <= st_d;
      sp_q      <= sp_d;
      cnt_q     <= cnt_d;
      addr_q    <= addr_d;
      cnthi_q   <= cnthi_d;
      wr_en_o   <= wr_en_d;
      wr_ext_o  <= wr_ext_d;
      wr_addr_o <= wr_addr_d;
      wr_data_o <= wr_data_d;
      rd_en_o   <= rd_en_d;
      rd_addr_o <= rd_addr_d;
      done_o    <= (st_d == ST_DONE);
    end
  end

  assert_rd_wr_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_o && wr_en_o));
  assert_rmw_follow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |=> ##1 (wr_en_o && !wr_ext_o && wr_addr_o == {8'h00, $past(rd_addr_o, 2)}));
  assert_done_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  assert_quiet_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!wr_en_o && !rd_en_o && !take_o));
  assert_stream_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DATA && vld_i && cnt_q != CNT_W'(1)) |=>
      (wr_en_o ##1 (wr_en_o && wr_addr_o == $past(wr_addr_o) + XAW'(1))));
endmodule

// File: rtl/init_table_loader.sv
module init_table_loader
  import initld_pkg::*;
#(
  parameter int         ROM_AW   = 10,
  parameter logic [7:0] XPAGE    = 8'hE6,
  parameter logic [7:0] BIT_BASE = 8'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ROM_AW-1:0] rom_addr_o,
  input  logic [7:0]        rom_data_i,
  output logic              wr_en_o,
  output logic              wr_ext_o,
  output logic [15:0]       wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              rd_en_o,
  output logic [7:0]        rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic              done_o
);
  logic       take, vld, bit_load;
  logic [7:0] byte_addr, merged;

  initld_fetch #(.ROM_AW(ROM_AW)) u_fetch (
    .clk_i, .rst_ni,
    .take_i     (take),
    .rom_addr_o (rom_addr_o),
    .vld_o      (vld)
  );

  initld_bitop #(.BIT_BASE(BIT_BASE)) u_bitop (
    .clk_i, .rst_ni,
    .load_i      (bit_load),
    .bit_byte_i  (rom_data_i),
    .rd_data_i   (rd_data_i),
    .byte_addr_o (byte_addr),
    .merged_o    (merged)
  );

  initld_seq #(.XPAGE(XPAGE)) u_seq (
    .clk_i, .rst_ni,
    .vld_i       (vld),
    .byte_i      (rom_data_i),
    .byte_addr_i (byte_addr),
    .merged_i    (merged),
    .take_o      (take),
    .bit_load_o  (bit_load),
    .wr_en_o     (wr_en_o),
    .wr_ext_o    (wr_ext_o),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o),
    .rd_en_o     (rd_en_o),
    .rd_addr_o   (rd_addr_o),
    .done_o      (done_o)
  );
endmodule

// File: tb/init_table_loader_bench.sv
module init_table_loader_bench;
  localparam int         ROM_AW   = 10;
  localparam int         ROM_N    = 1 << ROM_AW;
  localparam logic [7:0] XPAGE    = 8'hE6;
  localparam logic [7:0] BIT_BASE = 8'h20;
  localparam int         MAXW     = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [ROM_AW-1:0] rom_addr;
  logic [7:0]  rom_q, rd_q, wr_data, rd_addr;
  logic        wr_en, wr_ext, rd_en, done;
  logic [15:0] wr_addr;

  logic [7:0]  rom  [ROM_N];
  logic [7:0]  iram [256];
  logic [7:0]  emem [256];

  bit          exp_ext  [MAXW];
  logic [15:0] exp_addr [MAXW];
  logic [7:0]  exp_data [MAXW];
  int          n_exp;
  bit          act_ext  [MAXW];
  logic [15:0] act_addr [MAXW];
  logic [7:0]  act_data [MAXW];
  int          act_cyc  [MAXW];
  int          n_act;
  int          cyc = 0;
  int          checks = 0, failures = 0;
  int          wp;

  init_table_loader #(.ROM_AW(ROM_AW), .XPAGE(XPAGE), .BIT_BASE(BIT_BASE)) u_init_table_loader (
    .clk_i(clk), .rst_ni(rst_n), .rom_addr_o(rom_addr), .rom_data_i(rom_q),
    .wr_en_o(wr_en), .wr_ext_o(wr_ext), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_q), .done_o(done)
  );

  always @(posedge clk) begin
    rom_q <= rom[rom_addr];
    if (rd_en) rd_q <= iram[rd_addr];
    if (wr_en && !wr_ext) iram[wr_addr[7:0]] <= wr_data;
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && wr_en && n_act < MAXW) begin
      act_ext[n_act]  <= wr_ext;
      act_addr[n_act] <= wr_addr;
      act_data[n_act] <= wr_data;
      act_cyc[n_act]  <= cyc;
      n_act           <= n_act + 1;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic put(logic [7:0] b);
    rom[wp] = b;
    wp++;
  endtask

  task automatic push_exp(bit e, logic [15:0] a, logic [7:0] d);
    exp_ext[n_exp]  = e;
    exp_addr[n_exp] = a;
    exp_data[n_exp] = d;
    n_exp++;
  endtask

  // Model of the table format, written from the requirements
  task automatic build_expected();
    int p = 0;
    n_exp = 0;
    for (int i = 0; i < 256; i++) emem[i] = iram[i];
    while (p < ROM_N - 4) begin
      logic [7:0]  c = rom[p];
      logic [1:0]  sp = c[7:6];
      int          cnt;
      logic [15:0] a = 16'h0;
      p++;
      if (c[5]) begin cnt = {c[4:0], rom[p]}; p++; end
      else cnt = int'(c[4:0]);
      if (cnt == 0) break;
      if (sp == 2'b01) begin a = {rom[p], rom[p+1]}; p += 2; end
      else if (sp == 2'b00) begin a = {8'h00, rom[p]}; p++; end
      else if (sp == 2'b11) begin a = {XPAGE, rom[p]}; p++; end
      for (int k = 0; k < cnt; k++) begin
        logic [7:0] b = rom[p];
        p++;
        if (sp == 2'b10) begin
          logic [7:0] ba = BIT_BASE + {4'h0, b[6:3]};
          logic [7:0] v  = emem[ba];
          v[b[2:0]] = b[7];
          emem[ba] = v;
          push_exp(1'b0, {8'h00, ba}, v);
        end else begin
          push_exp(sp != 2'b00, a, b);
          if (sp == 2'b00) emem[a[7:0]] = b;
          a = a + 16'h1;
        end
      end
    end
  endtask

  task automatic prep();
    @(posedge clk); #1 rst_n = 1'b0;
    for (int i = 0; i < ROM_N; i++) rom[i] = 8'($urandom);
    for (int i = 0; i < 256; i++) iram[i] = 8'($urandom);
    wp = 0;
  endtask

  task automatic run(string name, bit chk_reset);
    int n_at_done;
    logic [ROM_AW-1:0] a_at_done;
    build_expected();
    n_act = 0;
    repeat (3) @(negedge clk);
    if (chk_reset) begin
      // R7: idle outputs while in reset
      check(!done && !wr_en && !rd_en, "R7", "reset strobes", {done, wr_en, rd_en}, 0);
      check(rom_addr == '0, "R7", "reset rom address", int'(rom_addr), 0);
    end
    @(posedge clk); #1 rst_n = 1'b1;
    for (int i = 0; i < 8000 && !done; i++) @(negedge clk);
    check(done, "R6", {name, " done raised"}, done, 1);
    n_at_done = n_act;
    a_at_done = rom_addr;
    repeat (20) @(negedge clk);
    check(n_act == n_at_done && rom_addr == a_at_done && done, "R6",
          {name, " quiet after done"}, n_act, n_at_done);
    check(n_act == n_exp, "R4", {name, " write count"}, n_act, n_exp);
    begin
      int bad = -1;
      for (int i = 0; i < n_act && i < n_exp; i++)
        if (bad < 0 && (act_ext[i] != exp_ext[i] || act_addr[i] != exp_addr[i] ||
                        act_data[i] != exp_data[i])) bad = i;
      if (bad >= 0)
        check(1'b0, "R1/R5", {name, " write content ext,addr,data"},
              {7'h0, act_ext[bad], act_addr[bad], act_data[bad]},
              {7'h0, exp_ext[bad], exp_addr[bad], exp_data[bad]});
      else
        check(1'b1, "R1", name, 0, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd7741));

    // R6: bare terminator
    prep(); put(8'h00);
    run("empty", 1'b1);
    check(n_act == 0, "R6", "empty table writes", n_act, 0);

    // R1 R2: one-byte external page
    prep(); put(8'hC3); put(8'h10); put(8'hAA); put(8'hBB); put(8'hCC); put(8'h00);
    run("short_ext", 1'b0);
    check(n_act == 3 && act_addr[0] == 16'hE610 && act_addr[2] == 16'hE612 && act_ext[0],
          "R2", "short ext count/addr", int'(act_addr[0]), 16'hE610);

    // R1: two-byte external, high byte first; then internal
    prep(); put(8'h42); put(8'h12); put(8'h34); put(8'h5A); put(8'hA5);
    put(8'h01); put(8'h3C); put(8'h77); put(8'h00);
    run("long_ext", 1'b0);
    check(act_addr[1] == 16'h1235 && act_ext[1], "R1", "long ext second addr", int'(act_addr[1]), 16'h1235);
    check(act_addr[2] == 16'h003C && !act_ext[2], "R1", "internal addr", int'(act_addr[2]), 16'h003C);

    // R3 R4 R8: extended count 0x105 across low-byte wrap
    prep(); put(8'h61); put(8'h05); put(8'h20); put(8'h00);
    for (int i = 0; i < 261; i++) put(8'(i));
    put(8'h00);
    run("ext_count", 1'b0);
    check(n_act == 261 && act_addr[260] == 16'h2104, "R3", "long count last addr", int'(act_addr[260]), 16'h2104);
    begin
      bit gapless = 1'b1;
      for (int i = 1; i < n_act; i++) if (act_cyc[i] != act_cyc[i-1] + 1) gapless = 1'b0;
      check(gapless, "R8", "payload writes on consecutive cycles", gapless, 1);
    end

    // R5: bit writes accumulate on one byte
    prep(); put(8'h83); put(8'h90); put(8'h97); put(8'h91); put(8'h00);
    iram[8'h22] = 8'h00;
    run("bits", 1'b0);
    check(n_act == 3 && act_data[2] == 8'h83 && act_addr[2] == 16'h0022, "R5",
          "bit accumulate", int'(act_data[2]), 8'h83);

    // R6: zero count in bit space, then long form zero
    prep(); put(8'h80); put(8'hC2); put(8'h00); put(8'h11); put(8'h22);
    run("zero_bit", 1'b0);
    check(n_act == 0, "R6", "zero count bit space", n_act, 0);
    prep(); put(8'hE0); put(8'h00); put(8'hC2); put(8'h00); put(8'h11); put(8'h22);
    run("zero_long", 1'b0);
    check(n_act == 0, "R6", "zero long count", n_act, 0);

    // random tables
    for (int t = 0; t < 20; t++) begin
      int nrec = 1 + int'($urandom % 6);
      prep();
      for (int r = 0; r < nrec; r++) begin
        logic [1:0] sp = 2'($urandom);
        bit lng = ($urandom % 5) == 0;
        int cnt = lng ? 32 + int'($urandom % 60) : 1 + int'($urandom % 31);
        if (lng) begin put({sp, 1'b1, 5'(cnt >> 8)}); put(8'(cnt)); end
        else put({sp, 1'b0, 5'(cnt)});
        if (sp == 2'b01) begin put(8'($urandom)); put(8'($urandom)); end
        else if (sp != 2'b10) put(8'($urandom));
        for (int k = 0; k < cnt; k++) put(8'($urandom));
      end
      case ($urandom % 3)
        0: put(8'h00);
        1: put({2'($urandom), 6'h00});
        default: begin put({2'($urandom), 6'h20}); put(8'h00); end
      endcase
      put(8'hC4); put(8'h01);
      run($sformatf("rand%0d", t), 1'b0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule